// File: doc/BRIEF.md
# Strap-sampled I2C configuration controller

This block configures a signal-conditioning device. Once the active-low reset is released, it waits a fixed number of clock cycles. At the end of that window it makes two decisions. First, it looks at the SCL and SDA lines to choose between I2C mode and strap-only mode. Second, it latches the already-decoded AC-boost and DC-boost strap levels into a small register file. Each strap level is stored as a thermometer-like three-bit code.

In I2C mode a byte-oriented I2C slave gives access to the register file. The slave supports writes with an offset byte, and reads through a repeated START, with the offset advancing on each byte. Both bus lines pass through a synchronizer and a glitch filter before the slave sees them. In strap-only mode the slave never answers.

A configuration-active bit holds the downstream state machine off. In strap-only mode this bit clears by itself when the window ends. In I2C mode it stays set until software clears it. Software applies new boost levels with a restart: it sets the bit and then clears it again.

Top module: `cfgc_top`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x2C. For any other address it leaves SDA released (sda_pull_o low), ignores the rest of the transaction and changes no register.
- R2: The mode decision is made at the SAMPLE_CYC-th rising clock edge after reset release, from the filtered line levels. I2C mode is selected only if SCL and SDA are both high. Otherwise the slave stays disabled until the next reset and never pulls SDA.
- R3: At the decision edge, eq_lvl_i values 0, 1, 2 and 3 load the codes 000, 001, 011 and 111 into bits 6:4 of register offset 0x01. acb_code_o shows this field from the clock after that edge.
- R4: At the decision edge, dcb_lvl_i values 0, 1, 2 and 3 load the codes 011, 101, 111 and 101 into bits 2:0 of register offset 0x0E. dcb_code_o shows this field.
- R5: Reset values apply during reset and until the decision: acb_code_o = 000, dcb_code_o = 101, and the configuration-active bit (offset 0x03 bit 0) = 1. sm_en_o is always the inverse of the configuration-active bit, so it is low until the decision.
- R6: In strap-only mode the configuration-active bit clears at the decision edge, so sm_en_o is high from the next clock.
- R7: In I2C mode the configuration-active bit stays 1 until an I2C write to offset 0x03 changes it. Writing 1 and then 0 first drops sm_en_o and then raises it again.
- R8: A write is START, then address with R/W = 0, then an offset byte, then data bytes. Each data byte is stored at the current offset, the offset then increments, and every byte is acknowledged.
- R9: A read is an offset write, then a repeated START, then address with R/W = 1. The slave then sends bytes from the current offset, incrementing the offset after each byte. It continues while the master acknowledges and releases SDA after a master NACK.
- R10: Writes to reserved bits (offset 0x01 bits 7 and 3:0, offset 0x03 bits 7:1, offset 0x0E bits 7:3) are ignored, and those bits read 0. Every other offset reads 0x00 and ignores writes.
- R11: A pulse on SCL or SDA shorter than FILT_LEN clock cycles is ignored. Such an SDA pulse while SCL is high neither aborts nor corrupts a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_pull_o | output | 1 | 1 = drive SDA low (open drain), 0 = release |
| eq_lvl_i | input | 2 | Decoded AC-boost strap level 0..3 |
| dcb_lvl_i | input | 2 | Decoded DC-boost strap code 0..3 |
| acb_code_o | output | 3 | Current AC-boost level code |
| dcb_code_o | output | 3 | Current DC-boost level code |
| sm_en_o | output | 1 | State-machine enable, high when not in configuration |

## Verification
The strap codes, the mode and the self-clearing of the configuration bit must appear right after the SAMPLE_CYC-th rising edge following reset release. The reference model counts edges from release and compares all three outputs on every falling edge against the reset values before that edge and the latched values after it.

A register write takes effect a few cycles after the SCL falling edge that ends the data byte: two synchronizer stages, FILT_LEN filter cycles, the slave register and the register-file register. The model therefore pauses its output comparison while a transfer is in flight, applies the write, and resumes comparing from ten cycles after STOP. An address NACK or a disabled slave must leave the outputs untouched, so comparison continues through those transfers.

Read data and acknowledge bits are sampled in the middle of the SCL high phase, well after the filtered falling edge at which the slave updates SDA.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

   localparam int unsigned BYTE_W = 8;

   // register offsets decoded by the register file
   localparam logic [BYTE_W-1:0] OFS_ACB = 8'h01;
   localparam logic [BYTE_W-1:0] OFS_CFG = 8'h03;
   localparam logic [BYTE_W-1:0] OFS_DCB = 8'h0E;

   localparam logic [2:0] ACB_RST = 3'b000;
   localparam logic [2:0] DCB_RST = 3'b101;

   typedef enum logic [2:0] {
      SL_IDLE,
      SL_ADDR,
      SL_ACK,
      SL_RX,
      SL_TX,
      SL_MACK
   } slv_state_e;

   // thermometer code: one more ones bit per level
   function automatic logic [2:0] acb_encode(input logic [1:0] lvl);
      return {lvl == 2'd3, lvl >= 2'd2, lvl >= 2'd1};
   endfunction

   // low / mid / high, the unused code falls back to mid
   function automatic logic [2:0] dcb_encode(input logic [1:0] lvl);
      logic [2:0] code;
      case (lvl)
         2'd0:    code = 3'b011;
         2'd2:    code = 3'b111;
         default: code = 3'b101;
      endcase
      return code;
   endfunction

endpackage

// File: rtl/cfgc_deglitch.sv
module cfgc_deglitch #(
   parameter int unsigned FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
      end else begin
         s1 <= din;
         s2 <= s1;
      end
   end

   if (FILT_LEN == 0) begin : g_pass
      assign dout = s2;
   end else begin : g_filt
      localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
      logic [CW-1:0] run;
      logic          q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            run <= '0;
            q   <= 1'b1;
         end else if (s2 == q) begin
            run <= '0;
         end else if (run == CW'(FILT_LEN - 1)) begin
            q   <= s2;
            run <= '0;
         end else begin
            run <= run + 1'b1;
         end
      end

      assign dout = q;

      // R11: the filtered level only moves after a change has persisted
      a_r11_filter_moves_on_persist: assert property (@(posedge clk) disable iff (!rst_n)
         (q != s2) && (run != CW'(FILT_LEN - 1)) |=> $stable(q));
   end

endmodule

// File: rtl/cfgc_i2c_slave.sv
module cfgc_i2c_slave
   import cfgc_pkg::*;
#(
   parameter logic [6:0] SLAVE_ADDR = 7'h2C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              scl_f,
   input  logic              sda_f,
   output logic              sda_pull_o,
   output logic              wr_en_o,
   output logic [BYTE_W-1:0] wr_addr_o,
   output logic [BYTE_W-1:0] wr_data_o,
   output logic [BYTE_W-1:0] rd_addr_o,
   input  logic [BYTE_W-1:0] rd_data_i
);

   localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

   slv_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg, ptr;
   logic              rw, first, from_addr, oe, mack, scl_q, sda_q;

   logic start_ev, stop_ev, scl_rise, scl_fall;
   assign start_ev = scl_f && scl_q && sda_q && !sda_f;
   assign stop_ev  = scl_f && scl_q && !sda_q && sda_f;
   assign scl_rise = scl_f && !scl_q;
   assign scl_fall = !scl_f && scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SL_IDLE;
         cnt       <= '0;
         shreg     <= '0;
         ptr       <= '0;
         rw        <= 1'b0;
         first     <= 1'b0;
         from_addr <= 1'b0;
         oe        <= 1'b0;
         mack      <= 1'b0;
         scl_q     <= 1'b1;
         sda_q     <= 1'b1;
         wr_en_o   <= 1'b0;
         wr_addr_o <= '0;
         wr_data_o <= '0;
      end else begin
         scl_q   <= scl_f;
         sda_q   <= sda_f;
         wr_en_o <= 1'b0;
         if (!en_i) begin
            st <= SL_IDLE;
            oe <= 1'b0;
         end else if (start_ev) begin
            st  <= SL_ADDR;
            cnt <= '0;
            oe  <= 1'b0;
         end else if (stop_ev) begin
            st <= SL_IDLE;
            oe <= 1'b0;
         end else begin
            case (st)
               SL_ADDR: begin
                  if (scl_rise && cnt != BYTE_DONE) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_f};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == BYTE_DONE) begin
                     if (shreg[BYTE_W-1:1] == SLAVE_ADDR) begin
                        rw        <= shreg[0];
                        first     <= 1'b1;
                        from_addr <= 1'b1;
                        oe        <= 1'b1;
                        st        <= SL_ACK;
                     end else begin
                        st <= SL_IDLE;
                     end
                  end
               end
               SL_ACK: begin
                  if (scl_fall) begin
                     from_addr <= 1'b0;
                     cnt       <= '0;
                     if (from_addr && rw) begin
                        shreg <= rd_data_i;
                        ptr   <= ptr + 8'd1;
                        oe    <= ~rd_data_i[BYTE_W-1];
                        st    <= SL_TX;
                     end else begin
                        oe <= 1'b0;
                        st <= SL_RX;
                     end
                  end
               end
               SL_RX: begin
                  if (scl_rise && cnt != BYTE_DONE) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_f};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && cnt == BYTE_DONE) begin
                     if (first) begin
                        ptr   <= shreg;
                        first <= 1'b0;
                     end else begin
                        wr_en_o   <= 1'b1;
                        wr_addr_o <= ptr;
                        wr_data_o <= shreg;
                        ptr       <= ptr + 8'd1;
                     end
                     oe <= 1'b1;
                     st <= SL_ACK;
                  end
               end
               SL_TX: begin
                  if (scl_fall) begin
                     if (cnt == LAST_BIT) begin
                        oe <= 1'b0;
                        st <= SL_MACK;
                     end else begin
                        cnt   <= cnt + 1'b1;
                        shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        oe    <= ~shreg[BYTE_W-2];
                     end
                  end
               end
               SL_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_f;
                  end else if (scl_fall) begin
                     if (mack) begin
                        shreg <= rd_data_i;
                        ptr   <= ptr + 8'd1;
                        oe    <= ~rd_data_i[BYTE_W-1];
                        cnt   <= '0;
                        st    <= SL_TX;
                     end else begin
                        st <= SL_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull_o = oe;
   assign rd_addr_o  = ptr;

   // R2: a disabled slave never pulls the data line
   a_r2_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !sda_pull_o);

   // R8: a data byte takes at least nine SCL periods, so writes never come back to back
   a_r8_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |=> !wr_en_o);

endmodule

// File: rtl/cfgc_regfile.sv
module cfgc_regfile
   import cfgc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              i2c_sel_i,
   input  logic [1:0]        eq_lvl_i,
   input  logic [1:0]        dcb_lvl_i,
   input  logic              wr_en_i,
   input  logic [BYTE_W-1:0] wr_addr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic [BYTE_W-1:0] rd_addr_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic [2:0]        acb_o,
   output logic [2:0]        dcb_o,
   output logic              cfg_o
);

   logic [2:0] acb_q, dcb_q;
   logic       cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acb_q <= ACB_RST;
         dcb_q <= DCB_RST;
         cfg_q <= 1'b1;
      end else if (load_i) begin
         acb_q <= acb_encode(eq_lvl_i);
         dcb_q <= dcb_encode(dcb_lvl_i);
         cfg_q <= i2c_sel_i;
      end else if (wr_en_i) begin
         case (wr_addr_i)
            OFS_ACB: acb_q <= wr_data_i[6:4];
            OFS_CFG: cfg_q <= wr_data_i[0];
            OFS_DCB: dcb_q <= wr_data_i[2:0];
            default: ;
         endcase
      end
   end

   // reserved write bits have no storage
   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_data_i[7], wr_data_i[3]};

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         OFS_ACB: rd_data_o[6:4] = acb_q;
         OFS_CFG: rd_data_o[0]   = cfg_q;
         OFS_DCB: rd_data_o[2:0] = dcb_q;
         default: ;
      endcase
   end

   assign acb_o = acb_q;
   assign dcb_o = dcb_q;
   assign cfg_o = cfg_q;

   // R6: strap-only mode leaves configuration at the decision
   a_r6_strap_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      load_i && !i2c_sel_i |=> !cfg_q);

   // R7: only the decision or a write to the config offset moves the bit
   a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i && !(wr_en_i && wr_addr_i == OFS_CFG) |=> $stable(cfg_q));

   // R3: a strap load always yields a thermometer code
   a_r3_acb_thermo: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> acb_q inside {3'b000, 3'b001, 3'b011, 3'b111});

   // R4: a strap load always yields one of the three DC codes
   a_r4_dcb_legal: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> dcb_q inside {3'b011, 3'b101, 3'b111});

endmodule

// File: rtl/cfgc_top.sv
module cfgc_top
   import cfgc_pkg::*;
#(
   parameter int unsigned SAMPLE_CYC = 16,
   parameter int unsigned FILT_LEN   = 3,
   parameter logic [6:0]  SLAVE_ADDR = 7'h2C
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_pull_o,
   input  logic [1:0] eq_lvl_i,
   input  logic [1:0] dcb_lvl_i,
   output logic [2:0] acb_code_o,
   output logic [2:0] dcb_code_o,
   output logic       sm_en_o
);

   localparam int unsigned WCW   = $clog2(SAMPLE_CYC + 1);
   localparam int unsigned LINES = 2;

   if (SAMPLE_CYC < FILT_LEN + 4) begin : g_chk_window
      $error("cfgc_top: SAMPLE_CYC must cover synchronizer and filter delay");
   end
   if (SLAVE_ADDR[6:3] == 4'b0000 || SLAVE_ADDR[6:3] == 4'b1111) begin : g_chk_addr
      $error("cfgc_top: SLAVE_ADDR lies in a reserved address group");
   end

   // index 1 = SCL, index 0 = SDA
   logic [LINES-1:0] line_raw, line_flt;
   assign line_raw = {scl_i, sda_i};

   for (genvar gi = 0; gi < LINES; gi++) begin : g_line
      cfgc_deglitch #(.FILT_LEN(FILT_LEN)) i_flt (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (line_raw[gi]),
         .dout (line_flt[gi])
      );
   end

   logic scl_f, sda_f;
   assign scl_f = line_flt[1];
   assign sda_f = line_flt[0];

   logic [WCW-1:0] win_cnt;
   logic           done, i2c_on, decide;

   assign decide = !done && (win_cnt == WCW'(SAMPLE_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         done    <= 1'b0;
         i2c_on  <= 1'b0;
      end else if (decide) begin
         done   <= 1'b1;
         i2c_on <= scl_f && sda_f;
      end else if (!done) begin
         win_cnt <= win_cnt + 1'b1;
      end
   end

   logic              wr_en;
   logic [BYTE_W-1:0] wr_addr, wr_data, rd_addr, rd_data;
   logic              cfg_act;

   cfgc_i2c_slave #(.SLAVE_ADDR(SLAVE_ADDR)) i_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (i2c_on),
      .scl_f     (scl_f),
      .sda_f     (sda_f),
      .sda_pull_o(sda_pull_o),
      .wr_en_o   (wr_en),
      .wr_addr_o (wr_addr),
      .wr_data_o (wr_data),
      .rd_addr_o (rd_addr),
      .rd_data_i (rd_data)
   );

   cfgc_regfile i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (decide),
      .i2c_sel_i(scl_f && sda_f),
      .eq_lvl_i (eq_lvl_i),
      .dcb_lvl_i(dcb_lvl_i),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_data_i(wr_data),
      .rd_addr_i(rd_addr),
      .rd_data_o(rd_data),
      .acb_o    (acb_code_o),
      .dcb_o    (dcb_code_o),
      .cfg_o    (cfg_act)
   );

   assign sm_en_o = ~cfg_act;

   // R5: the state machine stays off until the mode has been decided
   a_r5_hold_before_decision: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> !sm_en_o);

   // R2: no register write can occur outside I2C mode
   a_r2_no_write_in_strap: assert property (@(posedge clk) disable iff (!rst_n)
      !i2c_on |=> !wr_en);

endmodule

// File: tb/test_cfgc_top.sv
module test_cfgc_top;

   localparam int SAMPLE = 16;
   localparam int H      = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [1:0] eq_lvl = 2'd0;
   logic [1:0] dcb_lvl = 2'd0;
   logic       sda_pull;
   logic [2:0] acb_code, dcb_code;
   logic       sm_en;
   logic       sda_line;

   assign sda_line = sda_m & ~sda_pull;

   always #5 clk = ~clk;

   cfgc_top i_cfgc_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_pull_o(sda_pull),
      .eq_lvl_i  (eq_lvl),
      .dcb_lvl_i (dcb_lvl),
      .acb_code_o(acb_code),
      .dcb_code_o(dcb_code),
      .sm_en_o   (sm_en)
   );

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   // reference model state
   int         edges = 0;
   bit         chk_on = 1'b0;
   logic [2:0] m_acb, m_dcb;
   logic       m_cfg;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_acb(input logic [1:0] l);
      case (l)
         2'd0: return 3'b000;
         2'd1: return 3'b001;
         2'd2: return 3'b011;
         default: return 3'b111;
      endcase
   endfunction

   function automatic logic [2:0] exp_dcb(input logic [1:0] l);
      case (l)
         2'd0: return 3'b011;
         2'd2: return 3'b111;
         default: return 3'b101;
      endcase
   endfunction

   function automatic logic [7:0] model_read(input logic [7:0] ofs);
      case (ofs)
         8'h01: return {1'b0, m_acb, 4'b0000};
         8'h03: return {7'b0, m_cfg};
         8'h0E: return {5'b0, m_dcb};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_write(input logic [7:0] ofs, input logic [7:0] d);
      case (ofs)
         8'h01: m_acb = d[6:4];
         8'h03: m_cfg = d[0];
         8'h0E: m_dcb = d[2:0];
         default: ;
      endcase
   endtask

   always @(posedge clk) begin
      if (!rst_n) edges <= 0;
      else edges <= edges + 1;
   end

   // every-clock comparison of the outputs
   always @(negedge clk) begin
      if (chk_on && rst_n) begin
         if (edges < SAMPLE) begin
            chk("R5 acb before decision", int'(acb_code), 0);
            chk("R5 dcb before decision", int'(dcb_code), 5);
            chk("R5 sm_en before decision", int'(sm_en), 0);
         end else begin
            chk("R3 acb per clock", int'(acb_code), int'(m_acb));
            chk("R4 dcb per clock", int'(dcb_code), int'(m_dcb));
            chk("R6 sm_en per clock", int'(sm_en), int'(!m_cfg));
         end
      end
   end

   task automatic hw(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic scl_l, input logic sda_l, input logic [1:0] eq,
                           input logic [1:0] dc, input bit i2c);
      chk_on = 1'b0;
      @(negedge clk);
      rst_n   = 1'b0;
      scl_m   = scl_l;
      sda_m   = sda_l;
      eq_lvl  = eq;
      dcb_lvl = dc;
      hw(4);
      chk("R5 reset acb", int'(acb_code), 0);
      chk("R5 reset dcb", int'(dcb_code), 5);
      chk("R5 reset sm_en", int'(sm_en), 0);
      chk("R2 reset no pull", int'(sda_pull), 0);
      m_acb  = exp_acb(eq);
      m_dcb  = exp_dcb(dc);
      m_cfg  = i2c;
      rst_n  = 1'b1;
      chk_on = 1'b1;
      hw(SAMPLE + 10);
      chk("R3 strap acb", int'(acb_code), int'(exp_acb(eq)));
      chk("R4 strap dcb", int'(dcb_code), int'(exp_dcb(dc)));
      chk("R6 mode sm_en", int'(sm_en), int'(!i2c));
      scl_m = 1'b1;
      sda_m = 1'b1;
      hw(H);
   endtask

   // all bus tasks start and end with SCL low, half a phase into the low time
   task automatic i2c_start();
      sda_m = 1'b1; scl_m = 1'b1; hw(H);
      sda_m = 1'b0; hw(H);
      scl_m = 1'b0; hw(H / 2);
   endtask

   task automatic i2c_rstart();
      sda_m = 1'b1; hw(H / 2);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b0; hw(H);
      scl_m = 1'b0; hw(H / 2);
   endtask

   task automatic i2c_stop();
      sda_m = 1'b0; hw(H / 2);
      scl_m = 1'b1; hw(H);
      sda_m = 1'b1; hw(H);
   endtask

   task automatic i2c_wbyte(input logic [7:0] b, input int gbit, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hw(H / 2);
         scl_m = 1'b1;
         if (gbit == i) begin
            hw(H / 2); sda_m = 1'b0; hw(2); sda_m = 1'b1; hw(H / 2 - 2);
         end else begin
            hw(H);
         end
         scl_m = 1'b0; hw(H / 2);
      end
      sda_m = 1'b1; hw(H / 2);
      scl_m = 1'b1; hw(H / 2);
      ack = !sda_line;
      hw(H / 2);
      scl_m = 1'b0; hw(H / 2);
   endtask

   task automatic i2c_rbyte(output logic [7:0] b, input bit ack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hw(H / 2);
         scl_m = 1'b1; hw(H / 2);
         b[i] = sda_line;
         hw(H / 2);
         scl_m = 1'b0; hw(H / 2);
      end
      sda_m = !ack; hw(H / 2);
      scl_m = 1'b1; hw(H);
      scl_m = 1'b0; hw(H / 2);
      sda_m = 1'b1;
   endtask

   task automatic do_write(input string tag, input logic [6:0] a, input logic [7:0] ofs,
                           input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                           input int n, input int gbit, input bit exp_ack);
      bit         ack;
      logic [7:0] d [3];
      d[0] = d0; d[1] = d1; d[2] = d2;
      if (exp_ack) chk_on = 1'b0;
      i2c_start();
      i2c_wbyte({a, 1'b0}, -1, ack);
      chk({tag, " address ack"}, int'(ack), int'(exp_ack));
      if (ack) begin
         i2c_wbyte(ofs, -1, ack);
         chk({tag, " offset ack"}, int'(ack), 1);
         for (int k = 0; k < n; k++) begin
            i2c_wbyte(d[k], (k == n - 1) ? gbit : -1, ack);
            chk({tag, " data ack"}, int'(ack), 1);
         end
      end
      i2c_stop();
      if (exp_ack) begin
         for (int k = 0; k < n; k++) model_write(ofs + 8'(k), d[k]);
      end
      hw(10);
      chk_on = 1'b1;
      chk({tag, " acb after write"}, int'(acb_code), int'(m_acb));
      chk({tag, " dcb after write"}, int'(dcb_code), int'(m_dcb));
      chk({tag, " sm_en after write"}, int'(sm_en), int'(!m_cfg));
   endtask

   task automatic do_read(input string tag, input logic [7:0] ofs, input int n);
      bit         ack;
      logic [7:0] b;
      chk_on = 1'b0;
      i2c_start();
      i2c_wbyte({7'h2C, 1'b0}, -1, ack);
      chk({tag, " read address-w ack"}, int'(ack), 1);
      i2c_wbyte(ofs, -1, ack);
      chk({tag, " read offset ack"}, int'(ack), 1);
      i2c_rstart();
      i2c_wbyte({7'h2C, 1'b1}, -1, ack);
      chk({tag, " read address-r ack"}, int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         i2c_rbyte(b, k != n - 1);
         chk({tag, " read data"}, int'(b), int'(model_read(ofs + 8'(k))));
      end
      chk({tag, " released after nack"}, int'(sda_pull), 0);
      i2c_stop();
      hw(10);
      chk_on = 1'b1;
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      summary();
   end

   initial begin
      // strap-only: SCL low at the window end
      do_reset(1'b0, 1'b1, 2'd3, 2'd3, 1'b0);
      do_write("R2 slave disabled", 7'h2C, 8'h03, 8'h01, 8'h00, 8'h00, 1, -1, 1'b0);

      // strap-only: both lines low
      do_reset(1'b0, 1'b0, 2'd1, 2'd1, 1'b0);

      // strap-only: SDA low only
      do_reset(1'b1, 1'b0, 2'd0, 2'd2, 1'b0);

      // I2C mode, another strap pair
      do_reset(1'b1, 1'b1, 2'd1, 2'd2, 1'b1);

      // I2C mode, main register tests
      do_reset(1'b1, 1'b1, 2'd2, 2'd0, 1'b1);
      do_read("R9 R10 initial image", 8'h01, 3);
      do_write("R1 foreign address", 7'h2D, 8'h03, 8'h00, 8'h00, 8'h00, 1, -1, 1'b0);
      do_write("R7 clear config", 7'h2C, 8'h03, 8'h00, 8'h00, 8'h00, 1, -1, 1'b1);
      do_write("R8 burst write", 7'h2C, 8'h01, 8'h9F, 8'hAA, 8'h01, 3, -1, 1'b1);
      do_write("R7 restart", 7'h2C, 8'h03, 8'h00, 8'h00, 8'h00, 1, -1, 1'b1);
      do_write("R10 reserved dcb", 7'h2C, 8'h0E, 8'hFF, 8'h00, 8'h00, 1, -1, 1'b1);
      do_read("R10 reserved readback", 8'h0E, 2);
      do_write("R11 sda glitch", 7'h2C, 8'h0E, 8'h05, 8'h00, 8'h00, 1, 0, 1'b1);
      do_read("R9 acb readback", 8'h01, 1);

      summary();
   end

endmodule